// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block controls a successive-approximation analog-to-digital converter, one conversion at a time, in single-conversion mode. A prescaler divides the system clock into a converter clock. The converter clock is carried as a one-cycle enable pulse on the system clock, plus a second pulse at the falling half of each converter period. A cycle counter times each conversion in converter periods. The sequencer issues a sample-and-hold strobe and a strobe that latches the channel and reference selections into their active copies. It steps a 10-bit successive-approximation register, which is fed by one comparator bit. When the result is ready, it stores the result and raises a sticky completion flag.

Software switches the block on with the enable input. It requests a conversion by pulsing the start write. It then waits for the completion flag, or for the start bit to read back low. The first conversion after each enable is longer, so that the analog front end has time to settle. The sample point of that first conversion moves later by the same margin.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The converter clock has one rising event every D system clocks. D is 2 to the power (select + 1) for select values 0 to 6, and D is 128 for select 7. The prescaler count is held at zero while enable is low. The first rising event after enable therefore comes on the D-th clock edge with enable high.
- R2: A start request does not begin a conversion at once. `busy_o` rises on the first converter rising event after the start bit has been set.
- R3: A conversion other than the first one after enable keeps `busy_o` high for exactly 13 converter periods.
- R4: The first conversion after enable goes high keeps `busy_o` high for exactly 25 converter periods. Dropping enable re-arms this longer first conversion.
- R5: `sh_strobe_o` pulses for one clock. It follows the falling half-period event that lies 1.5 converter periods after the start of a normal conversion, and 14.5 periods after the start of a first conversion.
- R6: From the sample point on, the result register resolves one bit per converter period, most significant bit first. `dac_code_o` shows the trial code: the bits already kept, plus the bit under test. A comparator input of 1 keeps the bit under test. The stored result equals the largest code that the comparator accepts.
- R7: On completion, the result register is written, `done_o` is set and `start_o` is cleared, all on the same clock edge.
- R8: `done_o` stays set until a flag-clear write. If a completion and a clear happen in the same cycle, the flag is set.
- R9: Channel and reference selections are copied to `chan_act_o` and `ref_act_o`, with a one-clock `sel_latch_o` pulse, only when a conversion begins. A change to the selections during a conversion takes effect on the next conversion.
- R10: Dropping enable during a conversion aborts it. `busy_o` and `start_o` clear, and the result and the flag are left unchanged.
- R11: The 10-bit result is read as `res_hi_o` (bits 9:8 in bits 1:0, all upper bits zero) and `res_lo_o` (bits 7:0).
- R12: A start write has no effect while a conversion is running or while enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable |
| start_wr_i | input | 1 | One-cycle write that sets the start bit |
| flag_clr_i | input | 1 | One-cycle write-1 clear of the completion flag |
| presc_sel_i | input | 3 | Prescaler divide select |
| chan_sel_i | input | 2 | Requested channel |
| ref_sel_i | input | 2 | Requested reference |
| cmp_i | input | 1 | Comparator result for the present trial code |
| conv_tick_o | output | 1 | Converter-clock rising event (one system clock wide) |
| sh_strobe_o | output | 1 | Sample-and-hold strobe |
| sel_latch_o | output | 1 | Channel/reference latch strobe |
| chan_act_o | output | 2 | Active channel |
| ref_act_o | output | 2 | Active reference |
| dac_code_o | output | 10 | Trial code sent to the converter DAC |
| start_o | output | 1 | Start bit readback |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | Completion flag |
| res_hi_o | output | 8 | Result high byte |
| res_lo_o | output | 8 | Result low byte |

## Verification
The bench models the analog input as an integer compared against the trial code. It converts the values 0 and 1023, which tell apart a bit that is never kept from a bit that is always kept. It also converts the alternating patterns 341 and 682, which expose a wrong bit order or a shifted bit pointer, and the values 517, 100 and 900, which mix the high and low bytes. These conversions run under dividers of 2, 4, 8, 16 and 128 (select 6 and select 7). Each divider separates a wrong divide ratio from a wrong cycle count. The runs cover a first conversion, a normal conversion, a conversion cut short by disable, and start writes made while busy or disabled. The long and short lengths, and the abort re-arm, are each checked on their own.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
   // converter-clock events carried on the system clock
   typedef struct packed {
      logic rise;
      logic fall;
   } ctick_t;

   // number of result bits that fit the high readout byte
   function automatic int hi_bits(input int res_w);
      return res_w - 8;
   endfunction
endpackage

// File: rtl/adc_presc.sv
`timescale 1ns/1ps
module adc_presc
   import adc_seq_pkg::*;
#(
   parameter int SEL_W    = 3,
   parameter int MAX_LOG2 = 7
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic [SEL_W-1:0] sel_i,
   output ctick_t           tick_o
);
   localparam int SEL_N = 1 << SEL_W;

   if (MAX_LOG2 < 1 || MAX_LOG2 > 16) begin : g_bad_log2
      $error("adc_presc: MAX_LOG2 out of range");
   end

   logic [MAX_LOG2-1:0] cnt_q;
   logic [MAX_LOG2-1:0] mask_tab [SEL_N];
   logic [MAX_LOG2-1:0] mask;

   // divide ratio per select value, clamped at the widest divider
   for (genvar g = 0; g < SEL_N; g++) begin : g_mask
      localparam int LG = (g + 1 > MAX_LOG2) ? MAX_LOG2 : g + 1;
      assign mask_tab[g] = MAX_LOG2'((64'd1 << LG) - 64'd1);
   end

   assign mask = mask_tab[sel_i];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    cnt_q <= '0;
      else if (!en_i) cnt_q <= '0;
      else            cnt_q <= cnt_q + 1'b1;
   end

   assign tick_o.rise = en_i && ((cnt_q & mask) == mask);
   assign tick_o.fall = en_i && ((cnt_q & mask) == (mask >> 1));

   // two rising events are never on adjacent clocks
   p_tick_spacing_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o.rise |=> !tick_o.rise);
endmodule

// File: rtl/adc_sar.sv
`timescale 1ns/1ps
module adc_sar #(
   parameter int W = 10
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clr_i,
   input  logic         step_i,
   input  logic         cmp_i,
   output logic [W-1:0] code_o,
   output logic [W-1:0] val_o
);
   logic [W-1:0] acc_q, acc_d;
   logic [W-1:0] ptr_q;

   // per-bit decision: the bit under test takes the comparator verdict
   for (genvar b = 0; b < W; b++) begin : g_bit
      assign acc_d[b] = clr_i ? 1'b0
                      : (step_i && ptr_q[b]) ? cmp_i
                      : acc_q[b];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q <= '0;
         ptr_q <= '0;
      end else begin
         acc_q <= acc_d;
         if (clr_i)       ptr_q <= {1'b1, {(W-1){1'b0}}};
         else if (step_i) ptr_q <= ptr_q >> 1;
      end
   end

   assign code_o = acc_q | ptr_q;
   assign val_o  = acc_q;

   p_ptr_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(ptr_q));
   p_kept_bits_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && !clr_i) |=> ((acc_q & ~$past(code_o)) == '0));
endmodule

// File: rtl/adc_result_reg.sv
`timescale 1ns/1ps
module adc_result_reg #(
   parameter int W = 10
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] data_i,
   input  logic         clr_i,
   output logic [W-1:0] data_o,
   output logic         flag_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         data_o <= '0;
         flag_o <= 1'b0;
      end else begin
         if (load_i) data_o <= data_i;
         if (load_i)     flag_o <= 1'b1;
         else if (clr_i) flag_o <= 1'b0;
      end
   end

   p_flag_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o && !clr_i) |=> flag_o);
   p_data_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> $stable(data_o));
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int RES_W        = 10,
   parameter int SEL_W        = 3,
   parameter int MAX_DIV_LOG2 = 7,
   parameter int CH_W         = 2,
   parameter int REF_W        = 2,
   parameter int NORM_CYC     = 13,
   parameter int FIRST_CYC    = 25,
   parameter int NORM_SH      = 2,
   parameter int FIRST_SH     = 15
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             start_wr_i,
   input  logic             flag_clr_i,
   input  logic [SEL_W-1:0] presc_sel_i,
   input  logic [CH_W-1:0]  chan_sel_i,
   input  logic [REF_W-1:0] ref_sel_i,
   input  logic             cmp_i,
   output logic             conv_tick_o,
   output logic             sh_strobe_o,
   output logic             sel_latch_o,
   output logic [CH_W-1:0]  chan_act_o,
   output logic [REF_W-1:0] ref_act_o,
   output logic [RES_W-1:0] dac_code_o,
   output logic             start_o,
   output logic             busy_o,
   output logic             done_o,
   output logic [7:0]       res_hi_o,
   output logic [7:0]       res_lo_o
);
   localparam int MAX_CYC = (FIRST_CYC > NORM_CYC) ? FIRST_CYC : NORM_CYC;
   localparam int CYC_W   = $clog2(MAX_CYC + 1);
   localparam int HI_W    = hi_bits(RES_W);

   if (RES_W < 9 || RES_W > 16) begin : g_bad_res
      $error("adc_seq_ctrl: RES_W must lie in 9..16");
   end
   if (NORM_SH < 1 || NORM_SH + RES_W > NORM_CYC) begin : g_bad_norm
      $error("adc_seq_ctrl: normal conversion too short for its sample point");
   end
   if (FIRST_SH < 1 || FIRST_SH + RES_W > FIRST_CYC) begin : g_bad_first
      $error("adc_seq_ctrl: first conversion too short for its sample point");
   end

   ctick_t tick;
   logic   start_q, busy_q, first_q, first_run_q, sh_q, latch_q;
   logic [CYC_W-1:0] cyc_q, cyc_lim, sh_at, sh_end;
   logic [CH_W-1:0]  chan_q;
   logic [REF_W-1:0] ref_q;
   logic [RES_W-1:0] sar_val, res_q;
   logic begin_conv, finish, sar_step;

   adc_presc #(.SEL_W(SEL_W), .MAX_LOG2(MAX_DIV_LOG2)) u_presc (
      .clk_i (clk_i), .rst_ni(rst_ni), .en_i(en_i),
      .sel_i (presc_sel_i), .tick_o(tick)
   );

   // conversion profile selected by the first-after-enable marker
   assign cyc_lim = first_run_q ? CYC_W'(FIRST_CYC) : CYC_W'(NORM_CYC);
   assign sh_at   = first_run_q ? CYC_W'(FIRST_SH)  : CYC_W'(NORM_SH);
   assign sh_end  = sh_at + CYC_W'(RES_W);

   assign begin_conv = tick.rise && start_q && !busy_q;
   assign finish     = tick.rise && busy_q && (cyc_q == cyc_lim);
   assign sar_step   = tick.rise && busy_q && (cyc_q >= sh_at) && (cyc_q < sh_end);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         start_q     <= 1'b0;
         busy_q      <= 1'b0;
         first_q     <= 1'b1;
         first_run_q <= 1'b0;
         cyc_q       <= '0;
         sh_q        <= 1'b0;
         latch_q     <= 1'b0;
         chan_q      <= '0;
         ref_q       <= '0;
      end else if (!en_i) begin
         start_q <= 1'b0;
         busy_q  <= 1'b0;
         first_q <= 1'b1;
         cyc_q   <= '0;
         sh_q    <= 1'b0;
         latch_q <= 1'b0;
      end else begin
         sh_q    <= busy_q && tick.fall && (cyc_q == sh_at);
         latch_q <= begin_conv;
         if (finish)                   start_q <= 1'b0;
         else if (start_wr_i && !busy_q) start_q <= 1'b1;
         if (begin_conv) begin
            busy_q      <= 1'b1;
            cyc_q       <= CYC_W'(1);
            first_run_q <= first_q;
            chan_q      <= chan_sel_i;
            ref_q       <= ref_sel_i;
         end else if (finish) begin
            busy_q  <= 1'b0;
            cyc_q   <= '0;
            first_q <= 1'b0;
         end else if (tick.rise && busy_q) begin
            cyc_q <= cyc_q + 1'b1;
         end
      end
   end

   adc_sar #(.W(RES_W)) u_sar (
      .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(begin_conv), .step_i(sar_step),
      .cmp_i (cmp_i), .code_o(dac_code_o), .val_o(sar_val)
   );

   adc_result_reg #(.W(RES_W)) u_res (
      .clk_i (clk_i), .rst_ni(rst_ni), .load_i(finish), .data_i(sar_val),
      .clr_i (flag_clr_i), .data_o(res_q), .flag_o(done_o)
   );

   assign conv_tick_o = tick.rise;
   assign sh_strobe_o = sh_q;
   assign sel_latch_o = latch_q;
   assign chan_act_o  = chan_q;
   assign ref_act_o   = ref_q;
   assign start_o     = start_q;
   assign busy_o      = busy_q;
   assign res_hi_o    = 8'(res_q[RES_W-1:8]);
   assign res_lo_o    = res_q[7:0];

   p_fin_clears_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      finish |=> (!start_q && done_o));
   p_off_aborts_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (!busy_q && !start_q));
   p_cyc_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q |-> (cyc_q >= CYC_W'(1) && cyc_q <= cyc_lim));
   p_sh_in_conv_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sh_q |-> $past(busy_q));
   p_sel_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q |=> ($stable(chan_q) && $stable(ref_q)));
   p_begin_on_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_q) |-> $past(tick.rise));
   p_hi_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      res_hi_o[7:HI_W] == '0);
endmodule

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, start_wr = 1'b0, flag_clr = 1'b0;
   logic [2:0] sel = 3'd0;
   logic [1:0] chan = 2'd0, rsel = 2'd0;
   logic cmp;
   logic conv_tick_o, sh_strobe_o, sel_latch_o, start_o, busy_o, done_o;
   logic [1:0] chan_act_o, ref_act_o;
   logic [9:0] dac_code_o;
   logic [7:0] res_hi_o, res_lo_o;
   int vin = 0;
   int n_chk = 0, n_fail = 0, n_clk = 0;
   bit chk_on = 1'b0;

   always #10 clk = ~clk;

   assign cmp = (vin >= int'(dac_code_o));

   adc_seq_ctrl dut (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en), .start_wr_i(start_wr),
      .flag_clr_i(flag_clr), .presc_sel_i(sel), .chan_sel_i(chan),
      .ref_sel_i(rsel), .cmp_i(cmp), .conv_tick_o(conv_tick_o),
      .sh_strobe_o(sh_strobe_o), .sel_latch_o(sel_latch_o),
      .chan_act_o(chan_act_o), .ref_act_o(ref_act_o), .dac_code_o(dac_code_o),
      .start_o(start_o), .busy_o(busy_o), .done_o(done_o),
      .res_hi_o(res_hi_o), .res_lo_o(res_lo_o)
   );

   task automatic cmpv(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   function automatic int dv(int s);
      return (s >= 6) ? 128 : (2 << s);
   endfunction

   // behavioural reference model, advanced on every rising clock edge
   int m_cnt = 0, m_cyc = 0, m_res = 0, m_chan = 0, m_ref = 0;
   bit m_start = 0, m_busy = 0, m_first = 1, m_frun = 0, m_sh = 0, m_latch = 0, m_flag = 0;

   always @(posedge clk) begin
      int d, lim, sat;
      bit r, f, fin, beg;
      if (!rst_n) begin
         m_cnt = 0; m_cyc = 0; m_res = 0; m_chan = 0; m_ref = 0;
         m_start = 0; m_busy = 0; m_first = 1; m_frun = 0;
         m_sh = 0; m_latch = 0; m_flag = 0;
      end else begin
         d   = dv(int'(sel));
         r   = en && (m_cnt % d == d - 1);
         f   = en && (m_cnt % d == d / 2 - 1);
         lim = m_frun ? 25 : 13;
         sat = m_frun ? 15 : 2;
         fin = r && m_busy && (m_cyc == lim);
         beg = r && m_start && !m_busy;
         if (fin) begin m_flag = 1; m_res = vin; end
         else if (flag_clr) m_flag = 0;
         if (!en) begin
            m_cnt = 0; m_start = 0; m_busy = 0; m_first = 1;
            m_cyc = 0; m_sh = 0; m_latch = 0;
         end else begin
            m_sh    = m_busy && f && (m_cyc == sat);
            m_latch = beg;
            if (fin) m_start = 0;
            else if (start_wr && !m_busy) m_start = 1;
            if (beg) begin
               m_busy = 1; m_cyc = 1; m_frun = m_first;
               m_chan = int'(chan); m_ref = int'(rsel);
            end else if (fin) begin
               m_busy = 0; m_cyc = 0; m_first = 0;
            end else if (r && m_busy) m_cyc++;
            m_cnt = (m_cnt + 1) % 128;
         end
      end
   end

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      int d;
      if (rst_n && chk_on) begin
         d = dv(int'(sel));
         cmpv("R1 converter tick", conv_tick_o, (en && (m_cnt % d == d - 1)) ? 1 : 0);
         cmpv("R2 R3 R4 R10 busy", busy_o, m_busy);
         cmpv("R5 sample strobe", sh_strobe_o, m_sh);
         cmpv("R9 latch strobe", sel_latch_o, m_latch);
         cmpv("R9 active channel", chan_act_o, m_chan);
         cmpv("R9 active reference", ref_act_o, m_ref);
         cmpv("R7 R12 start bit", start_o, m_start);
         cmpv("R8 done flag", done_o, m_flag);
         cmpv("R6 R11 result high", res_hi_o, m_res >> 8);
         cmpv("R6 R11 result low", res_lo_o, m_res & 255);
      end
   end

   always @(posedge clk) begin
      n_clk++;
      if (n_clk > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog R2 act=%0d exp=%0d", n_clk, 150000);
         report();
      end
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic pulse_start();
      @(negedge clk); #1 start_wr = 1'b1;
      @(negedge clk); #1 start_wr = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk); #1 flag_clr = 1'b1;
      @(negedge clk); #1 flag_clr = 1'b0;
   endtask

   task automatic set_en(bit v);
      @(negedge clk); #1 en = v;
   endtask

   // one conversion; optional mid-run channel change and start write
   task automatic run_conv(int v, int nexp, string tag, int mid_chan);
      int n = 0, g = 0;
      vin = v;
      pulse_start();
      while (!busy_o && g < 2000) begin @(negedge clk); g++; end
      while (busy_o && n < 5000) begin
         n++;
         if (mid_chan >= 0 && n == nexp / 2) begin
            #1; chan = 2'(mid_chan); start_wr = 1'b1;
         end
         if (mid_chan >= 0 && n == nexp / 2 + 1) begin
            #1; start_wr = 1'b0;
         end
         @(negedge clk);
      end
      cmpv({tag, " conversion length"}, n, nexp);
      cmpv("R6 R11 result value", int'({res_hi_o[1:0], res_lo_o}), v);
      cmpv("R11 upper result bits zero", int'(res_hi_o[7:2]), 0);
      cmpv("R7 flag set at completion", done_o, 1);
      cmpv("R7 start bit cleared", start_o, 0);
      #1;
   endtask

   initial begin
      int keep;
      idle(3);
      rst_n = 1'b1;
      chk_on = 1'b1;
      idle(1);
      cmpv("R8 reset flag", done_o, 0);
      cmpv("R2 reset busy", busy_o, 0);
      cmpv("R7 reset start", start_o, 0);
      cmpv("R11 reset result", int'({res_hi_o, res_lo_o}), 0);

      // start while disabled is ignored
      pulse_start();
      idle(2);
      cmpv("R12 start ignored while disabled", start_o, 0);
      cmpv("R1 no tick while disabled", conv_tick_o, 0);

      sel = 3'd0; chan = 2'd1; rsel = 2'd2;
      set_en(1'b1);
      run_conv(517, 25 * 2, "R4 first after enable", -1);
      cmpv("R9 channel latched", chan_act_o, 1);
      pulse_clr();
      cmpv("R8 flag cleared by write", done_o, 0);
      run_conv(0, 13 * 2, "R3 normal", -1);

      // divide by 8; change channel and poke start mid-conversion
      sel = 3'd2;
      run_conv(1023, 13 * 8, "R3 normal div8", 3);
      cmpv("R9 mid-run change not applied", chan_act_o, 1);
      idle(3 * 8);
      cmpv("R12 start ignored while busy", busy_o, 0);
      cmpv("R12 start bit still clear", start_o, 0);
      cmpv("R8 flag held without clear", done_o, 1);
      run_conv(341, 13 * 8, "R3 normal alt", -1);
      cmpv("R9 new channel on next start", chan_act_o, 3);

      // re-enable gives a long first conversion again
      set_en(1'b0);
      sel = 3'd3;
      set_en(1'b1);
      run_conv(682, 25 * 16, "R4 first after re-enable", -1);

      // abort mid-conversion
      sel = 3'd1;
      pulse_clr();
      keep = int'({res_hi_o[1:0], res_lo_o});
      vin = 100;
      pulse_start();
      while (!busy_o) @(negedge clk);
      idle(20);
      en = 1'b0;
      idle(3);
      cmpv("R10 abort clears busy", busy_o, 0);
      cmpv("R10 abort clears start", start_o, 0);
      cmpv("R10 abort leaves flag", done_o, 0);
      cmpv("R10 abort leaves result", int'({res_hi_o[1:0], res_lo_o}), keep);
      set_en(1'b1);
      run_conv(100, 25 * 4, "R4 re-armed after abort", -1);

      sel = 3'd7;
      run_conv(900, 13 * 128, "R1 R3 select 7", -1);
      sel = 3'd6;
      rsel = 2'd1;
      run_conv(517, 13 * 128, "R1 R3 select 6", -1);
      cmpv("R9 reference latched", ref_act_o, 1);
      idle(5);
      report();
   end
endmodule